// File: doc/BRIEF.md
# Cache Parameter Search Controller

This controller tunes a configurable cache while the system runs. It changes one cache parameter at a time, in a fixed order: total size first, then line size, then associativity, then way prediction. For each candidate setting it first asks the cache to flush and waits for the acknowledge. It then drives the new configuration, starts a measurement window, and waits for an external energy estimator to return one energy figure with a valid pulse.

Within a parameter the controller keeps stepping to the next larger value while the measured energy keeps falling. When a candidate is no better, the controller goes back to the best setting so far and moves on to the next parameter. Because it never tries all combinations, it measures at most eight configurations. When the search ends, the winning configuration stays on the outputs and `done` stays high until the next `start`.

Top module: `cache_tune_fsm`

## Requirements
- R1: After reset the outputs show size=0, line=0, ways=0, wpred=0, with `busy`=0, `done`=0 and `eval_count`=0. A `start` pulse in idle or done sets `busy` from the next cycle, and the first configuration measured is that same all-zero starting point.
- R2: The encodings are as follows. Size 0/1/2 means 2/4/8 KB. Line 0/1/2 means 16/32/64 bytes. Ways 0/1/2 means 1/2/4 ways. The order of the search is size, then line, then ways, then way prediction, each stepping up by one code.
- R3: The controller moves to the next larger code only when the new energy is strictly below the best energy so far. On a tie or an increase it goes back to the best setting and moves to the next parameter.
- R4: A ways code larger than the size code (the number of active banks) is never applied; that step is skipped.
- R5: Way prediction is tried only when the best ways code is non-zero; `cfg_wpred`=1 never appears with ways code 0.
- R6: Every change of the configuration outputs, including the final return to the best setting, comes with `flush_req` held high until `flush_ack`. `meas_start` pulses for one cycle in the cycle after the acknowledge, and never at any other time.
- R7: `eval_count` counts the energy results accepted since `start`. It never exceeds 10; the largest possible value is 8.
- R8: At the end of the search the best configuration is held on the outputs, with `done`=1 and `busy`=0, until a new `start`.
- R9: `start` is ignored while `busy`, and `energy_valid` is ignored when no measurement is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search (one-cycle pulse) |
| energy | input | EW | Energy figure from the estimator |
| energy_valid | input | 1 | Energy figure is valid (one-cycle pulse) |
| flush_ack | input | 1 | Cache flush finished |
| flush_req | output | 1 | Cache flush request, held until acknowledged |
| meas_start | output | 1 | Start one measurement window (one-cycle pulse) |
| cfg_size | output | 2 | Total size code |
| cfg_line | output | 2 | Line size code |
| cfg_ways | output | 2 | Associativity code |
| cfg_wpred | output | 1 | Way prediction enable |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, best configuration applied |
| eval_count | output | CW | Configurations measured since start |

## Verification
The bench compares every search against a bench-side greedy walk over arithmetic energy landscapes. These are hashed landscapes over many seeds plus three directed ones: strictly falling (all steps taken, 8 results), flat (ties must revert, 3 results) and size-penalising (2 KB kept, so the ways and way-prediction steps must be skipped). A design that advanced on ties, never went back, or allowed 2 ways at 2 KB would end on a different configuration or count. A stray `energy_valid` while done, or a second `start` in the middle of a search, would show up as a changed configuration or an extra measurement. A missing flush before the final revert would show up as a measurement or configuration change without an acknowledge.

// File: rtl/cache_tune_fsm.sv
module cache_tune_fsm #(
  parameter int EW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [EW-1:0] energy,
  input  logic          energy_valid,
  input  logic          flush_ack,
  output logic          flush_req,
  output logic          meas_start,
  output logic [1:0]    cfg_size,
  output logic [1:0]    cfg_line,
  output logic [1:0]    cfg_ways,
  output logic          cfg_wpred,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] eval_count
);

  localparam int       CFGW   = 7;
  localparam logic [CFGW-1:0] INIT = '0;
  localparam logic [1:0] TOPC = 2'd2;
  localparam logic [CW-1:0] LIMIT = CW'(10);

  typedef enum logic [2:0] {S_IDLE, S_FLUSH, S_MEAS, S_DECIDE, S_ADV, S_DONE} st_t;
  typedef enum logic [2:0] {P_SIZE, P_LINE, P_WAYS, P_WPRED, P_END} ph_t;

  st_t              st;
  ph_t              ph;
  logic [CFGW-1:0]  cur, best, cand;
  logic [EW-1:0]    best_e, last_e;
  logic             fin, go, cand_ok, improved;

  assign {cfg_size, cfg_line, cfg_ways, cfg_wpred} = cur;
  assign flush_req  = (st == S_FLUSH);
  assign meas_start = go;
  assign busy       = (st != S_IDLE) && (st != S_DONE);
  assign improved   = (eval_count == CW'(1)) || (last_e < best_e);

  always_comb begin
    cand    = best;
    cand_ok = 1'b0;
    case (ph)
      P_SIZE:  if (best[6:5] < TOPC) begin cand[6:5] = best[6:5] + 2'd1; cand_ok = 1'b1; end
      P_LINE:  if (best[4:3] < TOPC) begin cand[4:3] = best[4:3] + 2'd1; cand_ok = 1'b1; end
      P_WAYS:  if (best[2:1] < TOPC && (best[2:1] + 2'd1) <= best[6:5]) begin
                 cand[2:1] = best[2:1] + 2'd1; cand_ok = 1'b1;
               end
      P_WPRED: if (best[2:1] != 2'd0 && !best[0]) begin cand[0] = 1'b1; cand_ok = 1'b1; end
      default: cand_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_SIZE; cur <= INIT; best <= INIT;
      best_e <= '0; last_e <= '0; fin <= 1'b0; go <= 1'b0;
      done <= 1'b0; eval_count <= '0;
    end else begin
      go <= 1'b0;
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            cur <= INIT; best <= INIT; ph <= P_SIZE; fin <= 1'b0;
            eval_count <= '0; done <= 1'b0; st <= S_FLUSH;
          end
        S_FLUSH:
          if (flush_ack) begin
            if (fin) begin st <= S_DONE; done <= 1'b1; end
            else begin st <= S_MEAS; go <= 1'b1; end
          end
        S_MEAS:
          if (energy_valid) begin
            last_e <= energy; eval_count <= eval_count + CW'(1); st <= S_DECIDE;
          end
        S_DECIDE: begin
          if (improved) begin best <= cur; best_e <= last_e; end
          else ph <= ph_t'(ph + 3'd1);
          st <= S_ADV;
        end
        S_ADV:
          if (cand_ok) begin cur <= cand; st <= S_FLUSH; end
          else if (ph == P_END) begin
            if (cur != best) begin cur <= best; fin <= 1'b1; st <= S_FLUSH; end
            else begin st <= S_DONE; done <= 1'b1; end
          end else ph <= ph_t'(ph + 3'd1);
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CFG_CHANGE_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> flush_req); // R6
  AST_MEAS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |-> $past(flush_ack)); // R6
  AST_WAYS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ways <= cfg_size); // R4
  AST_WPRED_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wpred |-> cfg_ways != 2'd0); // R5
  AST_EVAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    eval_count <= LIMIT); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(cur)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R8
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_size != 2'd3 && cfg_line != 2'd3 && cfg_ways != 2'd3); // R2

endmodule

// File: tb/test_cache_tune_fsm.sv
`timescale 1ns/1ps
module test_cache_tune_fsm;
  logic clk = 0, rst_n = 0, start = 0, energy_valid = 0, flush_ack = 0;
  logic [15:0] energy = '0;
  logic flush_req, meas_start, cfg_wpred, busy, done;
  logic [1:0] cfg_size, cfg_line, cfg_ways;
  logic [3:0] eval_count;
  int total = 0, bad = 0, cycles = 0;
  int mode = 0, seed = 0, meas_n = 0, max_cnt = 0;
  logic flushed = 0;
  logic [6:0] first_cfg;

  cache_tune_fsm i_cache_tune_fsm (.clk, .rst_n, .start, .energy, .energy_valid, .flush_ack,
    .flush_req, .meas_start, .cfg_size, .cfg_line, .cfg_ways, .cfg_wpred, .busy, .done, .eval_count);

  always #2.5 clk = ~clk;

  wire [6:0] cfg = {cfg_size, cfg_line, cfg_ways, cfg_wpred};

  function automatic int E(int m, int s, int c);
    int sz = (c >> 5) & 3, ln = (c >> 3) & 3, wy = (c >> 1) & 3, wp = c & 1;
    case (m)
      0: return (((c * 131 + s * 977) ^ (s * 53 + c * 29)) % 4096) + 1;
      1: return 1000 - 50 * sz - 40 * ln - 30 * wy - 20 * wp;
      2: return 500;
      default: return 500 + 100 * sz - 10 * ln + 5 * wy;
    endcase
  endfunction

  function automatic void ref_search(input int m, input int s, output logic [6:0] res, output int n);
    int b[4], c[4], be, e;
    logic ok, more;
    b = '{0, 0, 0, 0};
    be = E(m, s, 0);
    n = 1;
    for (int p = 0; p < 4; p++) begin
      more = 1;
      while (more) begin
        c = b; ok = 0;
        if (p == 0 && b[0] < 2) begin c[0]++; ok = 1; end
        if (p == 1 && b[1] < 2) begin c[1]++; ok = 1; end
        if (p == 2 && b[2] < 2 && b[2] + 1 <= b[0]) begin c[2]++; ok = 1; end
        if (p == 3 && b[2] > 0 && b[3] == 0) begin c[3] = 1; ok = 1; end
        if (!ok) more = 0;
        else begin
          e = E(m, s, c[0] * 32 + c[1] * 8 + c[2] * 2 + c[3]);
          n++;
          if (e < be) begin b = c; be = e; end else more = 0;
        end
      end
    end
    res = 7'(b[0] * 32 + b[1] * 8 + b[2] * 2 + b[3]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  // estimator and flush responder
  initial forever begin
    @(negedge clk);
    flush_ack = 0;
    energy_valid = 0;
    if (flush_req) begin
      repeat (seed % 3) @(negedge clk);
      flush_ack = 1;
      flushed = 1;
    end else if (meas_start) begin
      if (!flushed) begin bad++; total++; $display("FAIL R6 actual=%0d expected=%0d", 0, 1); end
      flushed = 0;
      if (meas_n == 0) first_cfg = cfg;
      meas_n++;
      repeat (1 + seed % 4) @(negedge clk);
      energy = 16'(E(mode, seed, int'(cfg)));
      energy_valid = 1;
    end
  end

  // property monitor on ports
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (int'(eval_count) > max_cnt) max_cnt = int'(eval_count);
      if (cfg_ways > cfg_size) begin bad++; $display("FAIL R4 actual=%0d expected<=%0d", cfg_ways, cfg_size); end
      if (cfg_wpred && cfg_ways == 0) begin bad++; $display("FAIL R5 actual=%0d expected=%0d", cfg_ways, 1); end
    end
  end

  initial begin
    @(negedge clk);
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic run(input int m, input int s, input bit mid_start);
    logic [6:0] exp_cfg, held;
    int exp_n, t;
    logic [3:0] held_cnt;
    mode = m; seed = s; meas_n = 0; max_cnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy === 1'b1 && done === 1'b0, "R1 busy after start", busy, 1);
    ref_search(m, s, exp_cfg, exp_n);
    if (mid_start) begin
      repeat (7) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    t = 0;
    while (done !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    check(first_cfg == 7'd0, "R1 first config", first_cfg, 0);
    check(cfg == exp_cfg, "R2 R3 final config", cfg, exp_cfg);
    check(int'(eval_count) == exp_n, "R7 eval count", eval_count, exp_n);
    check(meas_n == exp_n, "R9 measurements requested", meas_n, exp_n);
    check(max_cnt <= 10, "R7 count bound", max_cnt, 10);
    held = cfg; held_cnt = eval_count;
    repeat (3) @(negedge clk);
    energy = 16'd0; energy_valid = 1;
    @(negedge clk); energy_valid = 0;
    repeat (3) @(negedge clk);
    check(done === 1'b1 && busy === 1'b0 && cfg == held, "R8 R9 done held", cfg, held);
    check(eval_count == held_cnt, "R9 stray energy_valid", eval_count, held_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cfg == 7'd0 && !busy && !done && eval_count == 0, "R1 reset state", cfg, 0);
    check(!flush_req && !meas_start, "R6 idle handshake", flush_req, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    energy_valid = 1; @(negedge clk); energy_valid = 0;
    @(negedge clk);
    check(eval_count == 0 && !busy, "R9 energy_valid in idle", eval_count, 0);
    run(1, 0, 0);
    check(cfg == 7'b1010101, "R2 falling landscape reaches top", cfg, 7'b1010101);
    run(2, 1, 0);
    check(eval_count == 3, "R3 ties revert", eval_count, 3);
    run(3, 2, 0);
    check(cfg_size == 0 && cfg_ways == 0 && !cfg_wpred, "R4 R5 2KB skips ways", cfg_ways, 0);
    run(1, 3, 1);
    for (int s = 0; s < 60; s++) run(0, s, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule